// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller sits in front of an SRAM array whose every cell has a nonvolatile shadow. It decides when the whole array is copied into the shadow (a store) and when the shadow is copied back (a recall). A store can start in three ways: a hardware request, a software command, or a drop in supply. The hardware request arrives on an active-low pin that the block also pulls low itself to signal busy. The software command comes as a one-cycle strobe from an external sequence decoder. The supply drop comes from a power-good comparator.

The block keeps a dirty latch that records any accepted SRAM write. Supply-fail stores and hardware stores only run when that latch is set, while software stores always run. A hardware request first lets accesses already in flight drain for a fixed delay, and only then starts the transfer. The block gates the SRAM port through two registered inhibits. It tells the array to begin with one-cycle start pulses. A transfer ends when the array reports done, or when a cycle budget for that transfer runs out. All durations are parameters counted in clock cycles.

Top module: `nvstore_sequencer`

## Requirements
- R1: After reset, no recall starts while `pwr_good` is low, and `rw_inhibit` stays 1. Once `pwr_good` is high, exactly one `recall_start` pulse is issued, and `rw_inhibit` falls once that recall completes.
- R2: A dirty latch is set by an `sram_we` strobe in a cycle where `wr_inhibit` is 0, and is cleared when a store or a recall completes. A hardware request only starts a store while the latch is set.
- R3: A `sw_store` strobe taken in idle with supply good always starts a store, whether or not the latch is set.
- R4: After `req_pin_n` goes low with the latch set, `store_start` pulses exactly SYNC_STAGES+1+DRAIN_CYC cycles later. In the drain window before that pulse, reads are allowed and writes are blocked (`rw_inhibit`=0, `wr_inhibit`=1).
- R5: `busy_pull` (1 = drive the request pin low) is 1 from the start of the drain window, or from the start of any store, until the store completes. It is 0 at all other times. Each start pulse lasts one cycle.
- R6: A hardware request made while the latch is clear starts no store and leaves `busy_pull` at 0. It holds `rw_inhibit` at 1 until `req_pin_n` is seen high again. After any store, the block also waits for the pin to read high before it reopens the port.
- R7: `rw_inhibit` and `wr_inhibit` are 1 during every store and recall. A write strobe given while `wr_inhibit` is 1 does not set the latch.
- R8: While `pwr_good` is low, the port is fully inhibited, and software commands and hardware requests start nothing.
- R9: A transfer ends at `xfer_done`, or after STORE_CYC cycles (store) or RECALL_CYC cycles (recall), whichever comes first.
- R10: `sw_store` and `sw_recall` strobes that arrive while a transfer or drain is in progress are dropped, not queued.
- R11: When `pwr_good` falls in idle with the latch set, a store starts at once, with no drain. After it completes, a recall follows once supply returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pin_n | input | 1 | Level read back from the shared request/busy pin (low = request or busy) |
| pwr_good | input | 1 | Supply-above-threshold comparator, asynchronous |
| sw_store | input | 1 | One-cycle software store command |
| sw_recall | input | 1 | One-cycle software recall command |
| sram_we | input | 1 | Write strobe seen on the SRAM port |
| xfer_done | input | 1 | Array reports that the current transfer has finished |
| busy_pull | output | 1 | 1 = pull the request/busy pin low (open drain) |
| rw_inhibit | output | 1 | Block all SRAM reads and writes |
| wr_inhibit | output | 1 | Block SRAM writes |
| store_start | output | 1 | One-cycle pulse that starts an array store |
| recall_start | output | 1 | One-cycle pulse that starts an array recall |

## Verification
The hardest case to reach is the one where a write is refused: the blocked write leaves no trace except that a later, conditional store fails to happen. The bench sets up that case in several steps. It first empties the dirty latch with a completed store. It then holds the request pin low, so that the port is inhibited without a transfer, and strobes a write in that window. After releasing the pin, it makes a fresh hardware request and checks that no store pulse follows. Commands dropped during a transfer are shown the same way. The bench delays the modelled array's done response, fires both software strobes into the busy window, and then compares the totals of store and recall pulses.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_PWR = 3'd0,  // supply low or not yet up, port closed
    ST_IDLE     = 3'd1,  // port open
    ST_DRAIN    = 3'd2,  // hardware store pending, in-flight accesses finish
    ST_STORE    = 3'd3,  // array -> shadow copy running
    ST_RECALL   = 3'd4,  // shadow -> array copy running
    ST_HOLD     = 3'd5   // wait for request pin to read high
  } seq_state_e;

  typedef struct packed {
    logic busy;
    logic rw_inh;
    logic wr_inh;
  } seq_out_t;

  function automatic seq_out_t decode_out(seq_state_e s);
    seq_out_t o;
    o = '{busy: 1'b0, rw_inh: 1'b1, wr_inh: 1'b1};
    case (s)
      ST_IDLE:   o = '{busy: 1'b0, rw_inh: 1'b0, wr_inh: 1'b0};
      ST_DRAIN:  o = '{busy: 1'b1, rw_inh: 1'b0, wr_inh: 1'b1};
      ST_STORE:  o = '{busy: 1'b1, rw_inh: 1'b1, wr_inh: 1'b1};
      default:   o = '{busy: 1'b0, rw_inh: 1'b1, wr_inh: 1'b1};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/nvs_level_sync.sv
module nvs_level_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/nvs_dirty_latch.sv
module nvs_dirty_latch (
  input  logic clk,
  input  logic rst,
  input  logic wr_strobe_i,
  input  logic wr_blocked_i,
  input  logic clear_i,
  output logic dirty_o
);

  always_ff @(posedge clk) begin
    if (rst)                             dirty_o <= 1'b0;
    else if (clear_i)                    dirty_o <= 1'b0;
    else if (wr_strobe_i && !wr_blocked_i) dirty_o <= 1'b1;
  end

  AST_BLOCKED_WRITE_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_strobe_i && wr_blocked_i && !dirty_o) |=> !dirty_o); // R7

  AST_CLEAR_EMPTIES_LATCH: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !dirty_o); // R2

endmodule

// File: rtl/nvs_cycle_timer.sv
module nvs_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || restart_i)     cnt_o <= '0;
    else if (cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
  end

  AST_TIMER_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_o == '0)); // R9

endmodule

// File: rtl/nvstore_sequencer.sv
module nvstore_sequencer
  import nvs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DRAIN_CYC   = 8,
  parameter int STORE_CYC   = 1000,
  parameter int RECALL_CYC  = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic req_pin_n,
  input  logic pwr_good,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic sram_we,
  input  logic xfer_done,
  output logic busy_pull,
  output logic rw_inhibit,
  output logic wr_inhibit,
  output logic store_start,
  output logic recall_start
);

  localparam int MAX_A   = (DRAIN_CYC > STORE_CYC) ? DRAIN_CYC : STORE_CYC;
  localparam int MAX_CYC = (MAX_A > RECALL_CYC) ? MAX_A : RECALL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] DRAIN_LAST  = CNT_W'(DRAIN_CYC - 1);
  localparam logic [CNT_W-1:0] STORE_LAST  = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] RECALL_LAST = CNT_W'(RECALL_CYC - 1);

  seq_state_e       state_q, state_d;
  seq_out_t         out_d;
  logic             pin_hi_s, pwr_s;
  logic             dirty;
  logic [CNT_W-1:0] cnt;
  logic             drain_end, xfer_end, state_chg;

  // asynchronous pins into the clock domain
  nvs_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst(rst), .d_i(req_pin_n), .q_o(pin_hi_s));

  nvs_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
    .clk(clk), .rst(rst), .d_i(pwr_good), .q_o(pwr_s));

  nvs_dirty_latch u_dirty (
    .clk(clk), .rst(rst),
    .wr_strobe_i(sram_we), .wr_blocked_i(wr_inhibit),
    .clear_i(xfer_end), .dirty_o(dirty));

  nvs_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .restart_i(state_chg), .cnt_o(cnt));

  assign drain_end = (state_q == ST_DRAIN) && (cnt == DRAIN_LAST);
  assign xfer_end  = ((state_q == ST_STORE)  && (xfer_done || cnt == STORE_LAST)) ||
                     ((state_q == ST_RECALL) && (xfer_done || cnt == RECALL_LAST));
  assign state_chg = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_PWR: if (pwr_s) state_d = ST_RECALL;
      ST_IDLE: begin
        if (!pwr_s)          state_d = dirty ? ST_STORE : ST_WAIT_PWR;
        else if (!pin_hi_s)  state_d = dirty ? ST_DRAIN : ST_HOLD;
        else if (sw_store)   state_d = ST_STORE;
        else if (sw_recall)  state_d = ST_RECALL;
      end
      ST_DRAIN:  if (drain_end) state_d = ST_STORE;
      ST_STORE:  if (xfer_end)  state_d = pwr_s ? ST_HOLD : ST_WAIT_PWR;
      ST_RECALL: if (xfer_end)  state_d = pwr_s ? ST_IDLE : ST_WAIT_PWR;
      ST_HOLD: begin
        if (!pwr_s)        state_d = ST_WAIT_PWR;
        else if (pin_hi_s) state_d = ST_IDLE;
      end
      default: state_d = ST_WAIT_PWR;
    endcase
  end

  assign out_d = decode_out(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_WAIT_PWR;
      busy_pull    <= 1'b0;
      rw_inhibit   <= 1'b1;
      wr_inhibit   <= 1'b1;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
    end else begin
      state_q      <= state_d;
      busy_pull    <= out_d.busy;
      rw_inhibit   <= out_d.rw_inh;
      wr_inhibit   <= out_d.wr_inh;
      store_start  <= (state_d == ST_STORE)  && (state_q != ST_STORE);
      recall_start <= (state_d == ST_RECALL) && (state_q != ST_RECALL);
    end
  end

  AST_DRAIN_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |-> dirty); // R2

  AST_STARTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(store_start && recall_start)); // R1

  AST_BUSY_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
    busy_pull |-> (state_q == ST_DRAIN || state_q == ST_STORE)); // R5

  AST_STORE_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    store_start |=> !store_start); // R5

  AST_XFER_INHIBITS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STORE || state_q == ST_RECALL) |-> (rw_inhibit && wr_inhibit)); // R7

  AST_RW_IMPLIES_WR: assert property (@(posedge clk) disable iff (rst)
    rw_inhibit |-> wr_inhibit); // R7

  AST_NO_CMD_WHILE_STORE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STORE) |=> !recall_start); // R10

  AST_LOW_PWR_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_PWR) |=> !store_start); // R8

endmodule

// File: tb/nvstore_sequencer_tb.sv
`timescale 1ns/1ps
module nvstore_sequencer_tb;

  localparam int DRAIN = 8;
  localparam int STCYC = 200;
  localparam int RESP  = 20;

  localparam logic [3:0] OP_WR = 4'd0, OP_HW = 4'd1, OP_SWS = 4'd2,
                         OP_SWR = 4'd3, OP_PF = 4'd4;
  localparam int NVEC = 11;
  // {op, expected total stores, expected total recalls}
  localparam logic [15:0] VEC [NVEC] = '{
    {OP_WR,  6'd0, 6'd1},
    {OP_HW,  6'd1, 6'd1},
    {OP_HW,  6'd1, 6'd1},
    {OP_SWS, 6'd2, 6'd1},
    {OP_WR,  6'd2, 6'd1},
    {OP_SWR, 6'd2, 6'd2},
    {OP_HW,  6'd2, 6'd2},
    {OP_WR,  6'd2, 6'd2},
    {OP_PF,  6'd3, 6'd3},
    {OP_PF,  6'd3, 6'd4},
    {OP_SWS, 6'd4, 6'd4}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ext_low = 1'b0, pwr_good = 1'b0;
  logic sw_store = 1'b0, sw_recall = 1'b0, sram_we = 1'b0, xfer_done = 1'b0;
  logic busy_pull, rw_inhibit, wr_inhibit, store_start, recall_start;
  logic req_pin_n;
  logic resp_en = 1'b1;
  int   resp_cnt = 0;
  int   n_store = 0, n_recall = 0;
  int   n_chk = 0, n_bad = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  assign req_pin_n = !(ext_low || busy_pull);

  nvstore_sequencer #(.DRAIN_CYC(DRAIN), .STORE_CYC(STCYC)) u_dut (
    .clk(clk), .rst(rst), .req_pin_n(req_pin_n), .pwr_good(pwr_good),
    .sw_store(sw_store), .sw_recall(sw_recall), .sram_we(sram_we),
    .xfer_done(xfer_done), .busy_pull(busy_pull), .rw_inhibit(rw_inhibit),
    .wr_inhibit(wr_inhibit), .store_start(store_start), .recall_start(recall_start));

  // array model: answers each start pulse after RESP cycles
  always @(posedge clk) begin
    xfer_done <= 1'b0;
    if (store_start)  n_store  <= n_store + 1;
    if (recall_start) n_recall <= n_recall + 1;
    if (resp_cnt > 0) begin
      resp_cnt <= resp_cnt - 1;
      if (resp_cnt == 1) xfer_done <= 1'b1;
    end else if ((store_start || recall_start) && resp_en) begin
      resp_cnt <= RESP;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic do_hw();
    @(negedge clk); ext_low = 1'b1;
    cyc(60); ext_low = 1'b0; cyc(10);
  endtask

  task automatic do_pf();
    @(negedge clk); pwr_good = 1'b0; cyc(40);
    pwr_good = 1'b1; cyc(40);
  endtask

  initial begin
    int s0, r0, k;
    // reset state
    cyc(3);
    chk(rw_inhibit == 1'b1 && busy_pull == 1'b0 && store_start == 1'b0,
        "R7 reset outputs", rw_inhibit, 1);
    rst = 1'b0;
    cyc(10);
    chk(n_recall == 0, "R1 no recall while supply low", n_recall, 0);
    chk(rw_inhibit == 1'b1, "R8 port closed while supply low", rw_inhibit, 1);
    pwr_good = 1'b1;
    cyc(6);
    chk(n_recall == 1, "R1 power-up recall issued", n_recall, 1);
    chk(rw_inhibit == 1'b1, "R7 inhibit during recall", rw_inhibit, 1);
    cyc(30);
    chk(rw_inhibit == 1'b0, "R1 port open after recall", rw_inhibit, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][15:12])
        OP_WR:  pulse(sram_we);
        OP_HW:  do_hw();
        OP_SWS: begin pulse(sw_store); cyc(40); end
        OP_SWR: begin pulse(sw_recall); cyc(40); end
        default: do_pf();
      endcase
      chk(n_store == int'(VEC[i][11:6]),
          $sformatf("R2 R3 R11 store total after vector %0d", i), n_store, int'(VEC[i][11:6]));
      chk(n_recall == int'(VEC[i][5:0]),
          $sformatf("R11 recall total after vector %0d", i), n_recall, int'(VEC[i][5:0]));
    end

    // drain timing and busy drive
    pulse(sram_we);
    s0 = n_store;
    @(negedge clk); ext_low = 1'b1;
    k = 0;
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      if (j == 5) begin
        chk(wr_inhibit == 1'b1 && rw_inhibit == 1'b0, "R4 drain: reads open, writes blocked",
            {wr_inhibit, rw_inhibit}, 2);
        chk(busy_pull == 1'b1, "R5 busy driven in drain", busy_pull, 1);
      end
      if (store_start && k == 0) k = j;
      if (j == 15) chk(busy_pull && rw_inhibit, "R5 busy and inhibit during store",
                       {busy_pull, rw_inhibit}, 3);
    end
    chk(k == 3 + DRAIN, "R4 store start after drain", k, 3 + DRAIN);
    cyc(20);
    chk(busy_pull == 1'b0 && rw_inhibit == 1'b1, "R6 released busy, held while pin low",
        {busy_pull, rw_inhibit}, 1);
    ext_low = 1'b0; cyc(8);
    chk(rw_inhibit == 1'b0, "R6 port reopens after pin high", rw_inhibit, 0);

    // commands during a transfer are dropped
    s0 = n_store; r0 = n_recall;
    pulse(sw_store); cyc(4);
    pulse(sw_recall); pulse(sw_store);
    cyc(60);
    chk(n_store == s0 + 1, "R10 store total with commands during store", n_store, s0 + 1);
    chk(n_recall == r0, "R10 recall not queued", n_recall, r0);

    // blocked write under clear-latch request
    @(negedge clk); ext_low = 1'b1; cyc(10);
    chk(busy_pull == 1'b0, "R6 no busy with clear latch", busy_pull, 0);
    chk(rw_inhibit == 1'b1, "R6 port held with clear latch", rw_inhibit, 1);
    pulse(sram_we);
    ext_low = 1'b0; cyc(10);
    s0 = n_store;
    do_hw();
    chk(n_store == s0, "R7 blocked write left latch clear", n_store, s0);

    // low supply ignores commands
    s0 = n_store;
    @(negedge clk); pwr_good = 1'b0; cyc(10);
    chk(rw_inhibit == 1'b1 && busy_pull == 1'b0, "R8 low supply outputs",
        {rw_inhibit, busy_pull}, 2);
    pulse(sw_store); cyc(30);
    chk(n_store == s0, "R8 software store ignored at low supply", n_store, s0);
    pwr_good = 1'b1; cyc(40);

    // timeout ends a store without done
    resp_en = 1'b0;
    pulse(sw_store);
    cyc(195);
    chk(busy_pull == 1'b1, "R9 store still running before budget", busy_pull, 1);
    cyc(10);
    chk(busy_pull == 1'b0, "R9 store ended by budget", busy_pull, 0);
    cyc(10);
    chk(rw_inhibit == 1'b0, "R9 port open after budget", rw_inhibit, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule